// File: doc/BRIEF.md
# Master-Mode Video Sync Generator

This block produces the horizontal and vertical timing of a standard-definition TV raster on its own, with no external sync reference. It covers 525-line and 625-line systems, interlaced or progressive scan, and both 601-rate and square-pixel sampling. The block runs from a clock at twice the pixel rate, so every pixel position lasts two clocks. Four static inputs pick the format: line system, scan type, sampling grid, and how field parity is signalled on the vertical sync pin.

The outputs are active-low horizontal and vertical sync, a blanking flag, a colour-burst gate and a field-parity flag, all registered. A downstream encoder uses the sync pins to frame its input. It uses the blanking flag to force black level and the burst gate to insert the subcarrier reference. Field parity shows in the relative timing of the two sync falls. When the level mode is selected, the vertical sync pin instead carries the parity as a steady level.

Positions below count from zero. Pixel 0 is the leading edge of horizontal sync, and line 0 is the first line of the odd field. The frame line counts are parameters, default 525 and 625. A field holds the frame count divided by two, rounded down: 262 or 312 lines.

Top module: `vsg_top`

## Requirements
- R1: While `rst` is high, every output holds its idle value: `hsync_n`=1, `vsync_n`=1, `blank`=1, `burst_gate`=0, `field_odd`=1.
- R2: The raster position advances by one pixel every two clocks. Each output reflects position p=floor((k-1)/2) after the k-th rising edge following reset release. A line wraps after 858 (525-line, 601 rate), 780 (525-line, square), 864 (625-line, 601 rate) or 944 (625-line, square) pixels.
- R3: `hsync_n` is low for pixels 0 up to, but not including, the sync width: 63, 58, 63 or 69 for the four formats in the order of R2.
- R4: The odd field starts at pixel 0 of line 0. `vsync_n` falls there in the same clock as `hsync_n` and stays low for VS_LINES (default 3) whole lines.
- R5: In interlaced scan, `vsync_n` falls again at pixel total/2 of line F, where F is the field line count. This fall does not coincide with a `hsync_n` fall. The pin stays low until the same pixel of line F+VS_LINES.
- R6: In progressive scan, a frame is F lines long, every field is an odd field, and `field_odd` stays 1.
- R7: `field_odd` is 1 from the start of the odd field. It goes to 0 in the clock of the even-field vertical sync fall and stays 0 until the next frame starts.
- R8: With `fmt_field_level`=1, `vsync_n` carries the parity instead of a pulse: 1 in odd fields, 0 in even fields.
- R9: `burst_gate` is 1 from the burst start pixel for the burst length. The values (start/length) are 72/34, 65/31, 76/30 and 83/33 for the formats in the order of R2.
- R10: `burst_gate` stays 0 on the first 9 lines (525-line) or 7 lines (625-line) of each field. These lines count from the line in which that field's vertical sync falls.
- R11: `blank` is 1 on the lines of R10. On every other line it is 1 before the back-porch end (127, 115, 142, 155) and from total minus front porch (20, 18, 20, 22) onward, in the order of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt_625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line |
| fmt_interlace | input | 1 | 1 selects two interlaced fields per frame |
| fmt_square | input | 1 | 1 selects square-pixel line totals and timing |
| fmt_field_level | input | 1 | 1 makes `vsync_n` a field-parity level |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync (active low) or field level |
| blank | output | 1 | High during horizontal and vertical blanking |
| burst_gate | output | 1 | High where the colour burst belongs |
| field_odd | output | 1 | High during the odd field |

## Verification
The assertions assume that the four format inputs stay fixed from reset release onward; a format change without reset would break the counter relations they check. The stimulus therefore changes the format only while `rst` is high, and it releases reset on a falling clock edge. To cover whole frames in a short run, the bench shrinks the frame line counts to 25 and 21. That still leaves each field longer than the vertical-interval and sync windows, so every field-start and parity transition is visited. Expected values are rebuilt from the global pixel index after each edge, not from any counter inside the block.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HW = 12;
  typedef logic [HW-1:0] hpos_t;

  // Per-format horizontal timing, in pixels counted from the sync leading edge.
  typedef struct packed {
    hpos_t total;
    hpos_t sync_w;
    hpos_t burst_at;
    hpos_t burst_len;
    hpos_t porch_back;
    hpos_t porch_front;
  } hfmt_t;

  function automatic hfmt_t hfmt_lookup(input logic is625, input logic square);
    hfmt_t f;
    case ({is625, square})
      2'b00:   f = '{total: 858, sync_w: 63, burst_at: 72, burst_len: 34, porch_back: 127, porch_front: 20};
      2'b01:   f = '{total: 780, sync_w: 58, burst_at: 65, burst_len: 31, porch_back: 115, porch_front: 18};
      2'b10:   f = '{total: 864, sync_w: 63, burst_at: 76, burst_len: 30, porch_back: 142, porch_front: 20};
      default: f = '{total: 944, sync_w: 69, burst_at: 83, burst_len: 33, porch_back: 155, porch_front: 22};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/vsg_pix_tick.sv
module vsg_pix_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic adv
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign adv = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= '0;
    else          cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R2: one pixel step never follows another directly
      p_adv_spaced_r2: assert property (@(posedge clk) disable iff (rst)
        adv |=> !adv);
    end
  endgenerate
endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [HW-1:0] h_total,
  output logic [HW-1:0] pix_q,
  output logic          eol
);
  timeunit 1ns;
  timeprecision 1ps;

  assign eol = adv && (pix_q == h_total - HW'(1));

  always_ff @(posedge clk) begin
    if (rst)      pix_q <= '0;
    else if (eol) pix_q <= '0;
    else if (adv) pix_q <= pix_q + HW'(1);
  end

  p_pix_in_line_r2: assert property (@(posedge clk) disable iff (rst)
    pix_q < h_total);

  p_pix_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pix_q));
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
  parameter int HW       = 12,
  parameter int LW       = 10,
  parameter int VS_LINES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          eol,
  input  logic [HW-1:0] pix_q,
  input  logic [HW-1:0] h_half,
  input  logic [LW-1:0] l_total,
  input  logic [LW-1:0] l_field,
  input  logic          interlace,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] fline_q,
  output logic          field2_q,
  output logic          vs_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic pre_half, frame_end, half_hit, vs_end_odd, vs_end_even;

  always_comb begin
    pre_half    = (pix_q == h_half - HW'(1));
    frame_end   = eol && (line_q == l_total - LW'(1));
    half_hit    = adv && interlace && !field2_q && (line_q == l_field) && pre_half;
    vs_end_odd  = eol && !field2_q && (fline_q + LW'(1) == LW'(VS_LINES));
    vs_end_even = adv && field2_q && pre_half && (fline_q == LW'(VS_LINES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '0;
      fline_q  <= '0;
      field2_q <= 1'b0;
      vs_q     <= 1'b1;
    end else if (adv) begin
      if (frame_end) begin
        line_q   <= '0;
        fline_q  <= '0;
        field2_q <= 1'b0;
        vs_q     <= 1'b1;
      end else if (half_hit) begin
        field2_q <= 1'b1;
        fline_q  <= '0;
        vs_q     <= 1'b1;
      end else begin
        if (eol) begin
          line_q  <= line_q + LW'(1);
          fline_q <= fline_q + LW'(1);
        end
        if (vs_end_odd || vs_end_even) vs_q <= 1'b0;
      end
    end
  end

  p_line_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    line_q < l_total);

  p_no_field2_prog_r6: assert property (@(posedge clk) disable iff (rst)
    !interlace |-> !field2_q);

  p_vs_starts_field_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_q) |-> (fline_q == '0));
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
#(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  hfmt_t         fmt,
  input  hpos_t         pix_q,
  input  logic [LW-1:0] fline_q,
  input  logic [LW-1:0] vi_lines,
  input  logic          field2_q,
  input  logic          vs_q,
  input  logic          field_level,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank,
  output logic          burst_gate,
  output logic          field_odd
);
  timeunit 1ns;
  timeprecision 1ps;

  logic in_vi, in_sync, in_burst, in_hblank;

  always_comb begin
    in_vi     = (fline_q < vi_lines);
    in_sync   = (pix_q < fmt.sync_w);
    in_burst  = (pix_q >= fmt.burst_at) && (pix_q < fmt.burst_at + fmt.burst_len);
    in_hblank = (pix_q < fmt.porch_back) || (pix_q >= fmt.total - fmt.porch_front);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n    <= 1'b1;
      vsync_n    <= 1'b1;
      blank      <= 1'b1;
      burst_gate <= 1'b0;
      field_odd  <= 1'b1;
    end else begin
      hsync_n    <= !in_sync;
      vsync_n    <= field_level ? !field2_q : !vs_q;
      blank      <= in_vi || in_hblank;
      burst_gate <= !in_vi && in_burst;
      field_odd  <= !field2_q;
    end
  end

  // R9: the burst window always lies inside horizontal blanking
  p_burst_in_blank_r9: assert property (@(posedge clk) disable iff (rst)
    burst_gate |-> blank);

  // R3: sync and burst never overlap
  p_sync_burst_apart_r3: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !burst_gate);
endmodule

// File: rtl/vsg_top.sv
module vsg_top
  import vsg_pkg::*;
#(
  parameter int FRAME_LINES_525 = 525,
  parameter int FRAME_LINES_625 = 625,
  parameter int VS_LINES        = 3,
  parameter int VI_LINES_525    = 9,
  parameter int VI_LINES_625    = 7,
  parameter int CLKS_PER_PIX    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fmt_625,
  input  logic fmt_interlace,
  input  logic fmt_square,
  input  logic fmt_field_level,
  output logic hsync_n,
  output logic vsync_n,
  output logic blank,
  output logic burst_gate,
  output logic field_odd
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MAX_LINES = (FRAME_LINES_625 > FRAME_LINES_525) ? FRAME_LINES_625 : FRAME_LINES_525;
  localparam int LW        = $clog2(MAX_LINES + 1);
  localparam int FIELD_525 = FRAME_LINES_525 / 2;
  localparam int FIELD_625 = FRAME_LINES_625 / 2;

  hfmt_t         fmt;
  hpos_t         h_half, pix_q;
  logic [LW-1:0] l_field, l_total, vi_lines, line_q, fline_q;
  logic          adv, eol, field2_q, vs_q;

  always_comb begin
    fmt      = hfmt_lookup(fmt_625, fmt_square);
    h_half   = fmt.total >> 1;
    l_field  = fmt_625 ? LW'(FIELD_625) : LW'(FIELD_525);
    l_total  = !fmt_interlace ? l_field :
               (fmt_625 ? LW'(FRAME_LINES_625) : LW'(FRAME_LINES_525));
    vi_lines = fmt_625 ? LW'(VI_LINES_625) : LW'(VI_LINES_525);
  end

  vsg_pix_tick #(.DIV(CLKS_PER_PIX)) u_tick (
    .clk (clk),
    .rst (rst),
    .adv (adv)
  );

  vsg_hcount #(.HW(HW)) u_hcnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .h_total (fmt.total),
    .pix_q   (pix_q),
    .eol     (eol)
  );

  vsg_vcount #(.HW(HW), .LW(LW), .VS_LINES(VS_LINES)) u_vcnt (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .eol       (eol),
    .pix_q     (pix_q),
    .h_half    (h_half),
    .l_total   (l_total),
    .l_field   (l_field),
    .interlace (fmt_interlace),
    .line_q    (line_q),
    .fline_q   (fline_q),
    .field2_q  (field2_q),
    .vs_q      (vs_q)
  );

  vsg_decode #(.LW(LW)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .fmt         (fmt),
    .pix_q       (pix_q),
    .fline_q     (fline_q),
    .vi_lines    (vi_lines),
    .field2_q    (field2_q),
    .vs_q        (vs_q),
    .field_level (fmt_field_level),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .blank       (blank),
    .burst_gate  (burst_gate),
    .field_odd   (field_odd)
  );

  // R4/R5 parity: an odd-field vertical fall coincides with a horizontal fall, an even one does not
  p_parity_by_edges_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsync_n) && !fmt_field_level) |-> (field_odd == $fell(hsync_n)));

  // R6: progressive scan never reports an even field
  p_prog_all_odd_r6: assert property (@(posedge clk) disable iff (rst)
    !fmt_interlace |-> field_odd);

  // R7: parity only drops while the horizontal sync is inactive (mid-line)
  p_even_midline_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(field_odd) |-> hsync_n);
endmodule

// File: tb/vsg_top_tb_top.sv
module vsg_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FL525 = 25;
  localparam int FL625 = 21;
  localparam int VSL   = 3;

  typedef struct {
    logic [4:0] v;   // {hsync_n, vsync_n, blank, burst_gate, field_odd}
    string t_hs, t_vs, t_bl, t_bg, t_fo;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic f625 = 1'b0, fil = 1'b0, fsq = 1'b0, flv = 1'b0;
  logic hsync_n, vsync_n, blank, burst_gate, field_odd;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #2.5 clk = ~clk;

  vsg_top #(.FRAME_LINES_525(FL525), .FRAME_LINES_625(FL625), .VS_LINES(VSL)) dut_i (
    .clk             (clk),
    .rst             (rst),
    .fmt_625         (f625),
    .fmt_interlace   (fil),
    .fmt_square      (fsq),
    .fmt_field_level (flv),
    .hsync_n         (hsync_n),
    .vsync_n         (vsync_n),
    .blank           (blank),
    .burst_gate      (burst_gate),
    .field_odd       (field_odd)
  );

  // Expected outputs after the k-th rising edge since reset release.
  function automatic exp_t model(int k, bit a625, bit il, bit sq, bit lvl);
    exp_t e;
    int h, sw, bs, bl, bp, fp, lf, lt, p, pix, line, fline, vi;
    bit f2, vp, in_vi;
    if (!a625 && !sq)     begin h = 858; sw = 63; bs = 72; bl = 34; bp = 127; fp = 20; end
    else if (!a625 && sq) begin h = 780; sw = 58; bs = 65; bl = 31; bp = 115; fp = 18; end
    else if (a625 && !sq) begin h = 864; sw = 63; bs = 76; bl = 30; bp = 142; fp = 20; end
    else                  begin h = 944; sw = 69; bs = 83; bl = 33; bp = 155; fp = 22; end
    lf = (a625 ? FL625 : FL525) / 2;
    lt = il ? (a625 ? FL625 : FL525) : lf;
    vi = a625 ? 7 : 9;
    p = (k - 1) / 2;
    pix = p % h;
    line = (p / h) % lt;
    f2 = il && (line > lf || (line == lf && pix >= h / 2));
    fline = f2 ? line - lf : line;
    vp = f2 ? (line < lf + VSL || (line == lf + VSL && pix < h / 2)) : (line < VSL);
    in_vi = fline < vi;
    e.v[4] = !(pix < sw);
    e.v[3] = lvl ? !f2 : !vp;
    e.v[2] = in_vi || pix < bp || pix >= h - fp;
    e.v[1] = !in_vi && pix >= bs && pix < bs + bl;
    e.v[0] = !f2;
    e.t_hs = (pix == 0 || pix == h - 1) ? "R2" : "R3";
    e.t_vs = lvl ? "R8" : (f2 ? "R5" : "R4");
    e.t_bl = "R11";
    e.t_bg = in_vi ? "R10" : "R9";
    e.t_fo = il ? "R7" : "R6";
    return e;
  endfunction

  task automatic push_reset_item();
    exp_t e;
    e.v = 5'b11101;
    e.t_hs = "R1"; e.t_vs = "R1"; e.t_bl = "R1"; e.t_bg = "R1"; e.t_fo = "R1";
    sb_q.push_back(e);
  endtask

  task automatic run_case(bit a625, bit il, bit sq, bit lvl, int nclk);
    @(negedge clk);
    rst = 1'b1;
    f625 = a625; fil = il; fsq = sq; flv = lvl;
    repeat (3) begin
      @(posedge clk);
      push_reset_item();
    end
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= nclk; k++) begin
      @(posedge clk);
      sb_q.push_back(model(k, a625, il, sq, lvl));
    end
  endtask

  task automatic cmp(string tag, string name, logic act, logic exp);
    if (act !== exp) begin
      n_fail++;
      if (n_fail <= 25)
        $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle, away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_checks++;
      cmp(e.t_hs, "hsync_n",    hsync_n,    e.v[4]);
      cmp(e.t_vs, "vsync_n",    vsync_n,    e.v[3]);
      cmp(e.t_bl, "blank",      blank,      e.v[2]);
      cmp(e.t_bg, "burst_gate", burst_gate, e.v[1]);
      cmp(e.t_fo, "field_odd",  field_odd,  e.v[0]);
    end
  end

  initial begin
    // 525-line, 601 rate, interlaced, edge-coded parity: whole frame plus a margin
    run_case(1'b0, 1'b1, 1'b0, 1'b0, 858 * FL525 * 2 + 400);
    // 625-line, square pixel, interlaced, parity as vsync level (R8)
    run_case(1'b1, 1'b1, 1'b1, 1'b1, 944 * FL625 * 2 + 400);
    // 525-line, square pixel, progressive (R6)
    run_case(1'b0, 1'b0, 1'b1, 1'b0, 780 * (FL525 / 2) * 2 + 2000);
    // 625-line, 601 rate, progressive
    run_case(1'b1, 1'b0, 1'b0, 1'b0, 864 * (FL625 / 2) * 2 + 2000);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(180000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule